// File: doc/BRIEF.md
# Step/Direction Move Controller

This block drives a stepper motor driver through two wires, a step line and a direction line. It also keeps its own signed record of where the motor is assumed to be. A host hands it one move at a time. The move is either an absolute target position or a signed relative step count. The block then works out the direction and the number of steps, settles the direction line, and emits the step pulses at a programmable rate and width. The position register moves by one on every pulse, and the block reports completion with a one-cycle done strobe. The host does no work per step and needs no interrupts.

Moves enter through a valid/ready command port. `cmd_ready` is high only while the block is idle, and a command is taken in any cycle where `cmd_valid` and `cmd_ready` are both high. A requester that sees `cmd_ready` low must hold its command and wait; a command offered while a move runs is not taken and does not disturb that move. The pulse period and pulse width are sampled along with the command. An abort input stops a running move cleanly at the end of the current step period. All other pins are plain control and status.

Top module: `stepdir_move_ctrl`

## Requirements
- R1: A synchronous reset, at any time, sets the position to zero and sets step, dir, busy and done low, with cmd_ready high.
- R2: A command is taken only in a cycle where cmd_valid and cmd_ready are both high. cmd_ready is low for the whole of a move, and a command offered during a move is not taken: the move's step count and final position stay unchanged.
- R3: With cmd_rel=0, cmd_value is the absolute target. dir is 1 when the target is greater than the position (signed compare), and the move emits |target − position| steps and ends with position equal to the target.
- R4: With cmd_rel=1, cmd_value is a signed step count. dir is 1 for a positive count, the move emits |count| steps, and the position wraps modulo 2^POS_W.
- R5: dir takes its new value at the accepting clock edge and keeps it until the next move starts. The first step rising edge comes DIR_SETUP (default 2) cycles after the accepting edge, so it is first seen in cycle DIR_SETUP+1 after acceptance.
- R6: The position changes by exactly one, at the clock edge where step rises, and at no other time.
- R7: Each step pulse is high for max(step_high,1) cycles. Step rising edges are max(step_period, width+1) cycles apart. Both values are sampled when the command is taken.
- R8: One full step period after the last rising edge, busy falls and done is high for exactly one cycle. busy therefore lasts DIR_SETUP + N×period cycles for N steps.
- R9: A move that needs zero steps emits no pulse, leaves busy low, and raises done for one cycle in the cycle after acceptance.
- R10: An abort during a move ends it at the end of the current step period, or at the end of direction setup if no pulse has been emitted yet. The position then reflects exactly the pulses emitted, and done pulses once. An abort while idle has no effect.
- R11: dir=1 means the position counts up on each step and dir=0 means it counts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_rel | input | 1 | 1: cmd_value is a relative count; 0: absolute target |
| cmd_value | input | POS_W | Signed target or signed step count |
| step_period | input | TIME_W | Cycles between step rising edges |
| step_high | input | TIME_W | Cycles the step pulse stays high |
| abort | input | 1 | Stop the running move at the next period boundary |
| step | output | 1 | Step pulse to the motor driver |
| dir | output | 1 | Direction, 1 = positive |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle strobe at move completion |
| position | output | POS_W | Signed assumed motor position |

## Verification
The hardest situations to reach from the ports are the wrap-around moves, where the signed position must cross from its top value to its bottom value, and an abort that lands while direction setup is still in progress. The bench builds the position with a plain POS_W of 8 so that full-range moves across the wrap take only a few hundred cycles. It times the abort to the cycle by counting from the acceptance cycle, placing one abort inside the setup window and another in the middle of the third step period.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } sdm_state_e;
endpackage

// File: rtl/sdm_move_plan.sv
// Derives target, direction and step count for a newly offered command.
module sdm_move_plan #(
  parameter int POS_W = 16
) (
  input  logic [POS_W-1:0] cur_pos,
  input  logic             rel_mode,
  input  logic [POS_W-1:0] cmd_value,
  output logic [POS_W-1:0] target,
  output logic             dir_up,
  output logic [POS_W:0]   steps
);
  localparam int EXT_W = POS_W + 1;

  logic signed [EXT_W-1:0] cur_x;
  logic signed [EXT_W-1:0] val_x;
  logic signed [EXT_W-1:0] diff;

  always_comb begin
    cur_x = {cur_pos[POS_W-1], cur_pos};
    val_x = {cmd_value[POS_W-1], cmd_value};
    if (rel_mode) begin
      target = cur_pos + cmd_value;
      diff   = val_x;
    end else begin
      target = cmd_value;
      diff   = val_x - cur_x;
    end
    dir_up = ~diff[EXT_W-1];
    steps  = diff[EXT_W-1] ? $unsigned(-diff) : $unsigned(diff);
  end
endmodule

// File: rtl/sdm_position.sv
// Up/down record of the assumed motor position.
module sdm_position #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             dir_up,
  output logic [POS_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (fire) pos <= dir_up ? pos + 1'b1 : pos - 1'b1;
  end
endmodule

// File: rtl/sdm_sequencer.sv
// Move sequencing: direction setup, pulse timing, remaining count, abort.
module sdm_sequencer
  import sdm_pkg::*;
#(
  parameter int POS_W     = 16,
  parameter int TIME_W    = 16,
  parameter int DIR_SETUP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              zero_move,
  input  logic              dir_in,
  input  logic [POS_W:0]    steps_in,
  input  logic [TIME_W-1:0] period_in,
  input  logic [TIME_W-1:0] high_in,
  input  logic              abort,
  output logic              fire,
  output logic              step,
  output logic              dir,
  output logic              busy,
  output logic              done,
  output logic              rem_zero
);
  localparam int PER_W = TIME_W + 1;
  localparam int SC_W  = (DIR_SETUP > 1) ? $clog2(DIR_SETUP) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(DIR_SETUP - 1);

  sdm_state_e       state;
  logic [SC_W-1:0]  sc;
  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] hi_q;
  logic [POS_W:0]   rem;
  logic             abort_pend;
  logic             step_q;
  logic             dir_q;
  logic             done_q;

  logic [PER_W-1:0] hi_eff;
  logic [PER_W-1:0] per_eff;
  logic             abort_any;
  logic             setup_end;
  logic             period_end;
  logic             finish;

  always_comb begin
    hi_eff     = (high_in == '0) ? PER_W'(1) : {1'b0, high_in};
    per_eff    = ({1'b0, period_in} <= hi_eff) ? hi_eff + 1'b1 : {1'b0, period_in};
    abort_any  = abort_pend | abort;
    setup_end  = (state == ST_SETUP) && (sc == SC_LAST);
    period_end = (state == ST_RUN) && (phase == per_q - 1'b1);
    fire       = (setup_end && !abort_any) ||
                 (period_end && (rem != '0) && !abort_any);
    finish     = (setup_end && abort_any) ||
                 (period_end && ((rem == '0) || abort_any));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sc         <= '0;
      phase      <= '0;
      per_q      <= '0;
      hi_q       <= '0;
      rem        <= '0;
      abort_pend <= 1'b0;
      step_q     <= 1'b0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (zero_move) begin
              done_q <= 1'b1;
            end else begin
              state      <= ST_SETUP;
              dir_q      <= dir_in;
              rem        <= steps_in;
              hi_q       <= hi_eff;
              per_q      <= per_eff;
              sc         <= '0;
              abort_pend <= 1'b0;
            end
          end
        end
        ST_SETUP: begin
          if (abort)      abort_pend <= 1'b1;
          if (!setup_end) sc <= sc + 1'b1;
        end
        ST_RUN: begin
          if (abort) abort_pend <= 1'b1;
          if (!period_end) begin
            phase <= phase + 1'b1;
            if (phase == hi_q - 1'b1) step_q <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (fire) begin
        state  <= ST_RUN;
        step_q <= 1'b1;
        phase  <= '0;
        rem    <= rem - 1'b1;
      end
      if (finish) begin
        state      <= ST_IDLE;
        step_q     <= 1'b0;
        done_q     <= 1'b1;
        abort_pend <= 1'b0;
      end
    end
  end

  assign step     = step_q;
  assign dir      = dir_q;
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign rem_zero = (rem == '0);

  // R5
  dir_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(dir));

  generate
    if (DIR_SETUP >= 2) begin : g_setup_chk
      // R5
      dir_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(step) |-> (dir == $past(dir)) && (dir == $past(dir, 2)));
    end
  endgenerate
endmodule

// File: rtl/stepdir_move_ctrl.sv
// Step/direction move controller top.
module stepdir_move_ctrl #(
  parameter int POS_W     = 16,
  parameter int TIME_W    = 16,
  parameter int DIR_SETUP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rel,
  input  logic [POS_W-1:0]  cmd_value,
  input  logic [TIME_W-1:0] step_period,
  input  logic [TIME_W-1:0] step_high,
  input  logic              abort,
  output logic              step,
  output logic              dir,
  output logic              busy,
  output logic              done,
  output logic [POS_W-1:0]  position
);
  logic             accept;
  logic [POS_W-1:0] target_w;
  logic             dir_w;
  logic [POS_W:0]   steps_w;
  logic             fire;
  logic             rem_zero;
  logic [POS_W-1:0] target_q;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  sdm_move_plan #(.POS_W(POS_W)) u_plan (
    .cur_pos   (position),
    .rel_mode  (cmd_rel),
    .cmd_value (cmd_value),
    .target    (target_w),
    .dir_up    (dir_w),
    .steps     (steps_w)
  );

  sdm_sequencer #(
    .POS_W     (POS_W),
    .TIME_W    (TIME_W),
    .DIR_SETUP (DIR_SETUP)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .zero_move (steps_w == '0),
    .dir_in    (dir_w),
    .steps_in  (steps_w),
    .period_in (step_period),
    .high_in   (step_high),
    .abort     (abort),
    .fire      (fire),
    .step      (step),
    .dir       (dir),
    .busy      (busy),
    .done      (done),
    .rem_zero  (rem_zero)
  );

  sdm_position #(.POS_W(POS_W)) u_pos (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .dir_up (dir),
    .pos    (position)
  );

  always_ff @(posedge clk) begin
    if (rst)         target_q <= '0;
    else if (accept) target_q <= target_w;
  end

  // R6
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(step) |-> (dir ? (position == POS_W'($past(position) + 1'b1))
                         : (position == POS_W'($past(position) - 1'b1))));

  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(step) |-> $stable(position));

  // R3
  reach_chk: assert property (@(posedge clk) disable iff (rst)
    busy && rem_zero |-> position == target_q);

  // R8
  fin_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  step_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !step);
endmodule

// File: tb/stepdir_move_ctrl_tb.sv
module stepdir_move_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int TW = 8;
  localparam int SETUP = 2;
  localparam int WDOG = 150000;

  typedef struct packed {
    logic        rel;
    logic [7:0]  val;
    logic [7:0]  per;
    logic [7:0]  hi;
    logic [15:0] steps;
    logic        dir;
    logic [7:0]  pos;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd5,   8'd3, 8'd1, 16'd5,   1'b1, 8'd5},
    '{1'b1, 8'hF9,  8'd4, 8'd2, 16'd7,   1'b0, 8'hFE},
    '{1'b0, 8'hFE,  8'd3, 8'd1, 16'd0,   1'b0, 8'hFE},
    '{1'b0, 8'd3,   8'd0, 8'd0, 16'd5,   1'b1, 8'd3},
    '{1'b1, 8'd2,   8'd2, 8'd5, 16'd2,   1'b1, 8'd5},
    '{1'b0, 8'd120, 8'd2, 8'd1, 16'd115, 1'b1, 8'd120},
    '{1'b1, 8'd10,  8'd2, 8'd1, 16'd10,  1'b1, 8'h82},
    '{1'b0, 8'd127, 8'd2, 8'd1, 16'd253, 1'b1, 8'd127},
    '{1'b0, 8'h80,  8'd2, 8'd1, 16'd255, 1'b0, 8'h80},
    '{1'b1, 8'h80,  8'd2, 8'd1, 16'd128, 1'b0, 8'd0},
    '{1'b1, 8'd0,   8'd2, 8'd1, 16'd0,   1'b0, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_rel = 1'b0;
  logic [PW-1:0] cmd_value = '0;
  logic [TW-1:0] step_period = '0;
  logic [TW-1:0] step_high = '0;
  logic          abort = 1'b0;
  logic          step;
  logic          dir;
  logic          busy;
  logic          done;
  logic [PW-1:0] position;

  int n_chk = 0;
  int n_bad = 0;

  int r_rises, r_busy, r_high, r_first, r_done, r_done_at, r_dirbad, r_leak;
  bit r_timeout;

  stepdir_move_ctrl #(.POS_W(PW), .TIME_W(TW), .DIR_SETUP(SETUP)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rel(cmd_rel), .cmd_value(cmd_value), .step_period(step_period),
    .step_high(step_high), .abort(abort), .step(step), .dir(dir),
    .busy(busy), .done(done), .position(position)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int spos(input logic [PW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic do_move(input bit rel, input logic [PW-1:0] val,
                         input logic [TW-1:0] per, input logic [TW-1:0] hi,
                         input bit exp_dir, input int abort_c,
                         input int intr, input logic [PW-1:0] intr_val);
    bit prev_step, done_seen;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_rel = rel; cmd_value = val; step_period = per; step_high = hi;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_rises = 0; r_busy = 0; r_high = 0; r_first = -1; r_done = 0;
    r_done_at = -1; r_dirbad = 0; r_leak = 0; r_timeout = 1'b1;
    prev_step = 1'b0; done_seen = 1'b0;
    for (int c = 1; c <= 5000; c++) begin
      if (c > 1) @(negedge clk);
      if (busy) r_busy++;
      if (step) r_high++;
      if (step && !prev_step) begin
        r_rises++;
        if (r_first < 0) r_first = c;
      end
      prev_step = step;
      if (busy && dir != exp_dir) r_dirbad++;
      if (intr > 0 && c >= intr && c < intr + 3 && cmd_ready) r_leak++;
      if (done_seen) begin
        if (done) r_done++;
        r_timeout = 1'b0;
        break;
      end
      if (done) begin
        r_done++;
        r_done_at = c;
        done_seen = 1'b1;
      end
      abort = (c == abort_c);
      cmd_valid = (intr > 0 && c >= intr && c < intr + 3);
      if (cmd_valid) cmd_value = intr_val;
    end
    abort = 1'b0;
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", WDOG, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 state after reset
    check(position == '0, "R1", "position", spos(position), 0);
    check(!step && !busy && !done, "R1", "step|busy|done", int'({step, busy, done}), 0);
    check(cmd_ready && !dir, "R1", "ready,dir", int'({cmd_ready, dir}), 2);

    for (int i = 0; i < NV; i++) begin
      int eh, ep, eb;
      string tg;
      vec_t v;
      v = VECS[i];
      eh = (v.hi == 0) ? 1 : int'(v.hi);
      ep = (int'(v.per) <= eh) ? eh + 1 : int'(v.per);
      eb = (v.steps == 0) ? 0 : SETUP + int'(v.steps) * ep;
      tg = (v.steps == 0) ? "R9" : (v.rel ? "R4" : "R3");
      do_move(v.rel, v.val, v.per, v.hi, v.dir, 0, 0, '0);
      check(!r_timeout, tg, "completion", int'(r_timeout), 0);
      check(r_rises == int'(v.steps), tg, "step count", r_rises, int'(v.steps));
      check(position == v.pos, tg, "final position", spos(position), spos(v.pos));
      check(r_busy == eb, "R8", "busy cycles", r_busy, eb);
      check(r_done == 1, "R8", "done cycles", r_done, 1);
      check(r_done_at == eb + 1, "R8", "done cycle", r_done_at, eb + 1);
      if (v.steps != 0) begin
        // R7 pulse width and spacing follow from high total and busy length
        check(r_high == int'(v.steps) * eh, "R7", "high cycles", r_high, int'(v.steps) * eh);
        check(r_first == SETUP + 1, "R5", "first rise cycle", r_first, SETUP + 1);
        // R11 dir encoding
        check(r_dirbad == 0, "R11", "dir mismatches", r_dirbad, 0);
      end
    end

    // R2 command offered during a move is not taken
    do_move(1'b0, 8'd10, 8'd3, 8'd1, 1'b1, 0, 4, 8'hCE);
    check(r_leak == 0, "R2", "ready while busy", r_leak, 0);
    check(r_rises == 10, "R2", "step count", r_rises, 10);
    check(position == 8'd10, "R2", "final position", spos(position), 10);
    @(negedge clk);
    check(!busy && !step, "R2", "no second move", int'({busy, step}), 0);

    // R10 abort in third step period
    do_move(1'b0, 8'd0, 8'd4, 8'd1, 1'b0, 11, 0, '0);
    check(r_rises == 3, "R10", "steps before abort", r_rises, 3);
    check(position == 8'd7, "R10", "position after abort", spos(position), 7);
    check(r_busy == 14, "R10", "busy cycles", r_busy, 14);
    check(r_done == 1, "R10", "done cycles", r_done, 1);

    // R10 abort during direction setup
    do_move(1'b0, 8'd20, 8'd2, 8'd1, 1'b1, 1, 0, '0);
    check(r_rises == 0, "R10", "setup abort steps", r_rises, 0);
    check(position == 8'd7, "R10", "setup abort position", spos(position), 7);
    check(r_busy == 2 && r_done == 1, "R10", "setup abort busy", r_busy, 2);

    // R10 abort while idle has no effect
    abort = 1'b1;
    repeat (3) @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    check(!busy && !step && !done, "R10", "idle abort outputs", int'({busy, step, done}), 0);
    check(position == 8'd7, "R10", "idle abort position", spos(position), 7);
    do_move(1'b0, 8'd9, 8'd2, 8'd1, 1'b1, 0, 0, '0);
    check(r_rises == 2 && position == 8'd9, "R10", "move after idle abort", spos(position), 9);

    // R5 dir retained while idle after a move
    repeat (4) @(negedge clk);
    check(dir == 1'b1, "R5", "dir held idle", int'(dir), 1);

    // R1 reset in the middle of a move
    cmd_rel = 1'b0; cmd_value = 8'd50; step_period = 8'd2; step_high = 8'd1;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(position == '0, "R1", "position after mid-move reset", spos(position), 0);
    check(!step && !busy && !done && !dir, "R1", "outputs after mid-move reset",
          int'({step, busy, done, dir}), 0);
    check(cmd_ready, "R1", "ready after reset", int'(cmd_ready), 1);
    repeat (6) @(negedge clk);
    check(!step && position == '0, "R1", "stays idle", spos(position), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule